// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block runs on the host clock and reads an asynchronous, read-only parallel memory of 16M bits. The memory can be organised as 1M words of 16 bits or 512K words of 32 bits. A client asks for a burst with a start word address, a word count and a width flag. The controller then drives the memory's chip enable, output enable, width select and address pins. It waits a computed number of clock cycles before it samples the data bus, and it hands each word back on a valid/ready stream.

The memory answers faster when only the low, in-page address bits change. The controller therefore compares the page part of each new address with the previous one. It waits the short in-page delay when the page is unchanged, and the full random delay when the page differs or the word is the first of a burst. In 16-bit mode the top data pin of the memory is an address input carrying the lowest address bit, so the controller drives it; in 32-bit mode it releases that pin and reads it as data. Each nanosecond figure is turned into cycles as ceil(ns / clock period) + 1. With the default 20 ns clock, a random access takes 7 cycles, an in-page access 4 cycles, and the bus release gap 3 cycles.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), `rd_valid_o` is 0 and `req_ready_o` is 1.
- R2: The width flag is captured when a request is accepted and drives `mem_wide_o` for the whole burst. Flag value 1 means 32-bit words and 0 means 16-bit words.
- R3: In 16-bit mode, word address bit 0 goes out on `mem_a_m1_o` with `mem_a_m1_oe_o` = 1, and address bits 19:1 go on `mem_addr_o[18:0]`. In 32-bit mode, address bits 18:0 go on `mem_addr_o`, `mem_a_m1_oe_o` is 0, and request address bit 19 has no effect.
- R4: The first word of a burst is sampled after address, chip enable and output enable have been steady for RANDOM cycles. `rd_valid_o` rises RANDOM cycles (7 by default) after the accepting edge.
- R5: A later word whose page field (`mem_addr_o[18:2]`) equals that of the previous word is presented PAGE cycles (4 by default) after the handshake of the previous word.
- R6: A later word whose page field differs from that of the previous word waits RANDOM cycles after the previous handshake.
- R7: In 16-bit mode `rd_data_o` = {16'h0, bus[15:0]}. In 32-bit mode `rd_data_o` = bus[31:0].
- R8: While `rd_valid_o` = 1 and `rd_ready_i` = 0, the data, the address pins and the valid flag stay unchanged.
- R9: A burst returns `req_len_m1_i` + 1 words at consecutive word addresses. The address wraps at the top of the space: at 2^20 words in 16-bit mode and at 2^19 words in 32-bit mode.
- R10: At the edge that takes the last word, chip enable and output enable go high. `req_ready_o` then stays 0 for FLOAT cycles (3 by default), so chip enable stays high for at least the 40 ns float time.
- R11: Output enable is never low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_addr_i | input | 20 | Start word address |
| req_len_m1_i | input | 5 | Words in the burst minus one |
| req_wide_i | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| rd_valid_o | output | 1 | Returned word present |
| rd_ready_i | input | 1 | Consumer takes the returned word |
| rd_data_o | output | 32 | Returned word |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_wide_o | output | 1 | Memory width select, high for 32-bit |
| mem_addr_o | output | 19 | Memory address pins A0..A18 |
| mem_a_m1_o | output | 1 | Value driven on the top data pin as lowest address bit |
| mem_a_m1_oe_o | output | 1 | Drive enable for the top data pin |
| mem_d_i | input | 32 | Memory data bus |

## Verification
The first word of a burst is due RANDOM cycles after the accepting edge. Every later word is due PAGE or RANDOM cycles after the handshake edge of the word before it, depending on whether its page field matches. The bench counts rising edges and compares the count at the first falling edge where `rd_valid_o` is seen against those figures, worked out from its own model of the address sequence. The memory model drives X unless every access interval has passed in nanoseconds by one nanosecond before the sampling edge, so an early sample shows up as a data miscompare. After the last handshake the bench counts falling edges with `req_ready_o` low and expects exactly FLOAT of them.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_HOLD,
        ST_FLOAT
    } rd_state_e;

    // nanoseconds to wait cycles: rounded up, plus one sampling cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_addr_map.sv
// Maps a word address onto the memory pins for the current width and
// compares the page field of the current and the following word.
module prom_addr_map #(
    parameter int unsigned MEM_AW = 19,
    parameter int unsigned PG_LSB = 2
) (
    input  logic [MEM_AW:0]   cur_word_i,
    input  logic [MEM_AW:0]   nxt_word_i,
    input  logic              wide_i,
    output logic [MEM_AW-1:0] pin_a_o,
    output logic              a_m1_o,
    output logic              same_page_o
);
    logic [MEM_AW-1:0] nxt_pin_a;

    always_comb begin
        if (wide_i) begin
            pin_a_o   = cur_word_i[MEM_AW-1:0];
            nxt_pin_a = nxt_word_i[MEM_AW-1:0];
            a_m1_o    = 1'b0;
        end else begin
            pin_a_o   = cur_word_i[MEM_AW:1];
            nxt_pin_a = nxt_word_i[MEM_AW:1];
            a_m1_o    = cur_word_i[0];
        end
    end

    assign same_page_o = (pin_a_o[MEM_AW-1:PG_LSB] == nxt_pin_a[MEM_AW-1:PG_LSB]);

endmodule

// File: rtl/prom_wait_timer.sv
// Down counter: after a load of N, fin_o is high in the N-th cycle.
module prom_wait_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          fin_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fin_o = (cnt_q == ONE);

endmodule

// File: rtl/prom_lane_sel.sv
// Picks the live data lanes for the selected width.
module prom_lane_sel #(
    parameter int unsigned DW = 32
) (
    input  logic          wide_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] data_o
);
    localparam int unsigned HW = DW / 2;

    assign data_o = wide_i ? bus_i : {{HW{1'b0}}, bus_i[HW-1:0]};

endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
    import prom_rd_pkg::*;
#(
    parameter int unsigned CLK_NS     = 20,
    parameter int unsigned T_RAND_NS  = 120,
    parameter int unsigned T_CE_NS    = 120,
    parameter int unsigned T_OE_NS    = 50,
    parameter int unsigned T_PAGE_NS  = 50,
    parameter int unsigned T_FLOAT_NS = 40,
    parameter int unsigned MEM_AW     = 19,
    parameter int unsigned DW         = 32,
    parameter int unsigned LEN_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [MEM_AW:0]   req_addr_i,
    input  logic [LEN_W-1:0]  req_len_m1_i,
    input  logic              req_wide_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_wide_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              mem_a_m1_o,
    output logic              mem_a_m1_oe_o,
    input  logic [DW-1:0]     mem_d_i
);
    localparam int unsigned WAW       = MEM_AW + 1;
    localparam int unsigned RAND_CYC  = max_u(ns_to_cyc(T_RAND_NS, CLK_NS),
                                        max_u(ns_to_cyc(T_CE_NS, CLK_NS),
                                              ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int unsigned PAGE_CYC  = ns_to_cyc(T_PAGE_NS, CLK_NS);
    localparam int unsigned FLOAT_CYC = ns_to_cyc(T_FLOAT_NS, CLK_NS);
    localparam int unsigned MAX_CYC   = max_u(RAND_CYC, max_u(PAGE_CYC, FLOAT_CYC));
    localparam int unsigned CW        = $clog2(MAX_CYC + 1);

    localparam logic [MEM_AW-1:0] ONE_N = MEM_AW'(1);
    localparam logic [WAW-1:0]    ONE_W = WAW'(1);
    localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);

    typedef struct packed {
        rd_state_e        st;
        logic [WAW-1:0]   addr;
        logic [LEN_W-1:0] left;
        logic             wide;
        logic [DW-1:0]    data;
        logic             ce_n;
        logic             oe_n;
    } regs_t;

    regs_t r_d, r_q;

    logic           tmr_load;
    logic [CW-1:0]  tmr_val;
    logic           tmr_fin;
    logic [WAW-1:0] nxt_word;
    logic           same_page;
    logic [DW-1:0]  lane_data;

    prom_addr_map #(
        .MEM_AW (MEM_AW),
        .PG_LSB (2)
    ) u_map (
        .cur_word_i  (r_q.addr),
        .nxt_word_i  (nxt_word),
        .wide_i      (r_q.wide),
        .pin_a_o     (mem_addr_o),
        .a_m1_o      (mem_a_m1_o),
        .same_page_o (same_page)
    );

    prom_wait_timer #(
        .CW (CW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .fin_o  (tmr_fin)
    );

    prom_lane_sel #(
        .DW (DW)
    ) u_lane (
        .wide_i (r_q.wide),
        .bus_i  (mem_d_i),
        .data_o (lane_data)
    );

    // next word address, wrapping inside the space of the active width
    always_comb begin
        if (r_q.wide) begin
            nxt_word = {1'b0, r_q.addr[MEM_AW-1:0] + ONE_N};
        end else begin
            nxt_word = r_q.addr + ONE_W;
        end
    end

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.st   = ST_ACCESS;
                    r_d.wide = req_wide_i;
                    r_d.addr = req_wide_i ? {1'b0, req_addr_i[MEM_AW-1:0]} : req_addr_i;
                    r_d.left = req_len_m1_i;
                    r_d.ce_n = 1'b0;
                    r_d.oe_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RAND_CYC);
                end
            end
            ST_ACCESS: begin
                if (tmr_fin) begin
                    r_d.data = lane_data;
                    r_d.st   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (rd_ready_i) begin
                    if (r_q.left == '0) begin
                        r_d.st   = ST_FLOAT;
                        r_d.ce_n = 1'b1;
                        r_d.oe_n = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(FLOAT_CYC);
                    end else begin
                        r_d.st   = ST_ACCESS;
                        r_d.left = r_q.left - ONE_L;
                        r_d.addr = nxt_word;
                        tmr_load = 1'b1;
                        tmr_val  = same_page ? CW'(PAGE_CYC) : CW'(RAND_CYC);
                    end
                end
            end
            ST_FLOAT: begin
                if (tmr_fin) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, left: '0, wide: 1'b0,
                     data: '0, ce_n: 1'b1, oe_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o   = (r_q.st == ST_IDLE);
    assign rd_valid_o    = (r_q.st == ST_HOLD);
    assign rd_data_o     = r_q.data;
    assign mem_ce_n_o    = r_q.ce_n;
    assign mem_oe_n_o    = r_q.oe_n;
    assign mem_wide_o    = r_q.wide;
    assign mem_a_m1_oe_o = ~r_q.wide;

endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
    parameter int unsigned MEM_AW   = 19,
    parameter int unsigned DW       = 32,
    parameter int unsigned RAND_CYC = 7,
    parameter int unsigned PAGE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [DW-1:0]     rd_data_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_wide_o,
    input logic [MEM_AW-1:0] mem_addr_o,
    input logic              mem_a_m1_o
);
    localparam int unsigned AGE_W = $clog2(RAND_CYC + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    logic [MEM_AW-1:0] prev_a;
    logic              prev_m1;
    logic [AGE_W-1:0]  addr_age;
    logic [AGE_W-1:0]  ce_age;

    // cycles the address pins and the chip enable have been steady
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_a   <= '0;
            prev_m1  <= 1'b0;
            addr_age <= '0;
            ce_age   <= '0;
        end else begin
            prev_a  <= mem_addr_o;
            prev_m1 <= mem_a_m1_o;
            if (mem_addr_o != prev_a || mem_a_m1_o != prev_m1) begin
                addr_age <= AGE_ONE;
            end else if (addr_age != AGE_MAX) begin
                addr_age <= addr_age + AGE_ONE;
            end
            if (mem_ce_n_o) begin
                ce_age <= '0;
            end else if (ce_age != AGE_MAX) begin
                ce_age <= ce_age + AGE_ONE;
            end
        end
    end

    p_oe_inside_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_ce_n_o);

    p_hold_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)
                                      && $stable(mem_addr_o) && $stable(mem_a_m1_o));

    p_idle_bus_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> mem_ce_n_o);

    p_float_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n_o) |-> !req_ready_o);

    p_upper_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !mem_wide_o |-> rd_data_o[DW-1:DW/2] == '0);

    p_page_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> addr_age >= AGE_W'(PAGE_CYC));

    p_ce_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> ce_age >= AGE_W'(RAND_CYC));

endmodule

bind prom_page_reader prom_page_reader_chk #(
    .MEM_AW   (MEM_AW),
    .DW       (DW),
    .RAND_CYC (RAND_CYC),
    .PAGE_CYC (PAGE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready_o (req_ready_o),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rd_data_o   (rd_data_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_wide_o  (mem_wide_o),
    .mem_addr_o  (mem_addr_o),
    .mem_a_m1_o  (mem_a_m1_o)
);

// File: tb/tb_prom_page_reader.sv
`timescale 1ns/1ps
module tb_prom_page_reader;

    localparam int unsigned CLK_NS = 20;
    localparam int unsigned RANDOM = (120 + CLK_NS - 1) / CLK_NS + 1;
    localparam int unsigned PAGE   = (50 + CLK_NS - 1) / CLK_NS + 1;
    localparam int unsigned FLOAT  = (40 + CLK_NS - 1) / CLK_NS + 1;
    localparam int unsigned WD_CYC = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic        req_wide = 1'b0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        ce_n, oe_n, wide_pin, a_m1, a_m1_oe;
    logic [18:0] pin_a;
    logic [31:0] mem_d = 'z;

    int unsigned cyc = 0;
    int unsigned checks = 0;
    int unsigned fails = 0;

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prom_page_reader dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_ready_o   (req_ready),
        .req_addr_i    (req_addr),
        .req_len_m1_i  (req_len),
        .req_wide_i    (req_wide),
        .rd_valid_o    (rd_valid),
        .rd_ready_i    (rd_ready),
        .rd_data_o     (rd_data),
        .mem_ce_n_o    (ce_n),
        .mem_oe_n_o    (oe_n),
        .mem_wide_o    (wide_pin),
        .mem_addr_o    (pin_a),
        .mem_a_m1_o    (a_m1),
        .mem_a_m1_oe_o (a_m1_oe),
        .mem_d_i       (mem_d)
    );

    function automatic logic [15:0] word16(input logic [19:0] w);
        logic [31:0] t;
        t = {12'h0, w} * 32'h9E3779B1;
        return t[31:16] ^ w[15:0];
    endfunction

    function automatic logic [31:0] exp_data(input logic [19:0] a, input bit w);
        if (w) return {word16({a[18:0], 1'b1}), word16({a[18:0], 1'b0})};
        return {16'h0, word16(a)};
    endfunction

    function automatic logic [16:0] page_of(input logic [19:0] a, input bit w);
        return w ? a[18:2] : a[19:3];
    endfunction

    function automatic logic [19:0] step(input logic [19:0] a, input bit w);
        if (w) return {1'b0, a[18:0] + 19'd1};
        return a + 20'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model with access timing ----------------
    realtime t_any = 0, t_page = 0, t_ce = 0, t_oe = 0, t_ce_hi = 0;
    logic [16:0] last_pg = '0;
    bit ce_was_hi = 1'b0;

    always @(pin_a or a_m1 or wide_pin) begin
        t_any = $realtime;
        if (pin_a[18:2] != last_pg) begin
            t_page  = $realtime;
            last_pg = pin_a[18:2];
        end
    end
    always @(negedge oe_n) t_oe = $realtime;
    always @(posedge ce_n) begin
        t_ce_hi   = $realtime;
        ce_was_hi = 1'b1;
    end
    always @(negedge ce_n) begin
        t_ce = $realtime;
        if (ce_was_hi) // R10: bus released long enough before the next burst
            chk(($realtime - t_ce_hi) >= 40.0, "R10", "float gap ns",
                32'(int'($realtime - t_ce_hi)), 32'd40);
    end

    // outputs re-evaluated 1 ns before each rising edge
    always begin
        bit ok;
        @(negedge clk);
        #(CLK_NS / 2 - 1);
        if (ce_n || oe_n) begin
            mem_d = 'z;
        end else begin
            ok = ($realtime - t_page >= 120.0) && ($realtime - t_any >= 50.0) &&
                 ($realtime - t_ce >= 120.0) && ($realtime - t_oe >= 50.0);
            if (!wide_pin && !a_m1_oe) ok = 1'b0;
            if (!ok) mem_d = 'x;
            else if (wide_pin) mem_d = {word16({pin_a, 1'b1}), word16({pin_a, 1'b0})};
            else mem_d = {16'hzzzz, word16({pin_a, a_m1})};
            if (wide_pin && a_m1_oe) mem_d[31] = 1'bx;
        end
    end

    // ---------------- burst driver and checker ----------------
    task automatic burst(input logic [19:0] a, input int len_m1, input bit w, input int stall);
        logic [19:0] cur, prv;
        int unsigned t_ref, lat, n;
        logic [31:0] d0;
        logic [18:0] a0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_len   = 5'(len_m1);
        req_wide  = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t_ref = cyc;
        cur = w ? {1'b0, a[18:0]} : a;
        prv = cur;
        for (int k = 0; k <= len_m1; k++) begin
            bit seen = 1'b0;
            bit done = 1'b0;
            if (k == 0) lat = RANDOM;                            // R4
            else if (page_of(cur, w) == page_of(prv, w)) lat = PAGE; // R5
            else lat = RANDOM;                                   // R6
            while (!done) begin
                if (rd_valid) begin
                    if (!seen) begin
                        seen = 1'b1;
                        chk(cyc - t_ref == lat, (k == 0) ? "R4" :
                            (lat == PAGE ? "R5" : "R6"), "valid latency",
                            cyc - t_ref, lat);
                        chk(wide_pin === w, "R2", "width pin", 32'(wide_pin), 32'(w));
                        chk(pin_a === (w ? cur[18:0] : cur[19:1]), "R3", "address pins",
                            32'(pin_a), 32'(w ? cur[18:0] : cur[19:1]));
                        chk(a_m1_oe === !w && (w || a_m1 === cur[0]), "R3",
                            "top pin drive {oe,val}", {30'h0, a_m1_oe, a_m1},
                            {30'h0, !w, w ? 1'b0 : cur[0]});
                        chk(rd_data === exp_data(cur, w), "R7", "data word (R9 address order)",
                            rd_data, exp_data(cur, w));
                        d0 = rd_data;
                        a0 = pin_a;
                    end else begin
                        chk(rd_data === d0 && pin_a === a0, "R8", "stalled word steady",
                            rd_data, d0);
                    end
                    if (($urandom % 100) >= stall) begin
                        rd_ready = 1'b1;
                        @(negedge clk);
                        rd_ready = 1'b0;
                        t_ref = cyc;
                        done = 1'b1;
                    end else begin
                        @(negedge clk);
                    end
                end else begin
                    @(negedge clk);
                end
            end
            prv = cur;
            cur = step(cur, w);
        end
        // R10: bus released right after the last handshake, then the float wait
        chk(ce_n === 1'b1 && oe_n === 1'b1, "R10", "enables high after last word",
            {30'h0, ce_n, oe_n}, 32'h3);
        n = 0;
        while (!req_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == FLOAT, "R10", "ready-low cycles after burst", n, FLOAT);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (2) @(negedge clk);
        // R1: state while in reset and right after release
        chk(ce_n === 1'b1 && oe_n === 1'b1 && rd_valid === 1'b0 && req_ready === 1'b1,
            "R1", "reset outputs", {28'h0, ce_n, oe_n, rd_valid, req_ready}, 32'hD);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n === 1'b1 && oe_n === 1'b1 && rd_valid === 1'b0 && req_ready === 1'b1,
            "R1", "idle after reset", {28'h0, ce_n, oe_n, rd_valid, req_ready}, 32'hD);

        burst(20'h00000, 0, 1'b0, 0);   // R4 single word, 16-bit
        burst(20'h00005, 5, 1'b0, 0);   // R5/R6 page crossing at word 8
        burst(20'h00002, 4, 1'b1, 0);   // R6 32-bit crossing at word 4
        burst(20'hFFFFE, 3, 1'b0, 0);   // R9 wrap in 16-bit mode
        burst(20'hFFFFF, 2, 1'b1, 0);   // R3 bit 19 ignored, R9 wrap at 2^19
        burst(20'h1234B, 9, 1'b1, 80);  // R8 heavy backpressure
        burst(20'h0ABC7, 6, 1'b0, 60);  // R8 backpressure across a page
        burst(20'h00010, 31, 1'b0, 0);  // R9 longest burst

        for (int i = 0; i < 50; i++) begin
            logic [19:0] a;
            a = 20'($urandom);
            if (i % 4 == 0) a[2:0] = 3'b110;
            burst(a, int'($urandom % 20), bit'($urandom % 2), int'($urandom % 3) * 30);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual cycle %0d expected below %0d", cyc, WD_CYC);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule